// File: doc/BRIEF.md
# Eight-Port Butterfly Switching Fabric

This block is a self-routing multistage network that joins eight source ports to eight destination ports. It has four ranks of eight switching nodes, 32 nodes in all. Each source feeds one node in the first rank, and each destination is fed by one node in the last rank. Between two neighbouring ranks there are sixteen one-way links, so the fabric has 48 links. Every node holds one packet. It picks one of its two inputs by round-robin and forwards the packet on the output chosen by the leading bit of the packet's destination tag. As the packet leaves the node, that bit is removed from the tag.

A source presents a three-bit destination, a payload and a checksum with a valid/ready handshake. The fabric prefixes a header whose remaining length is three. Each of the first three ranks consumes one destination bit, most significant first. A packet therefore always crosses exactly three links and reaches its destination port with an empty header. The payload and checksum are untouched. Packets whose routes share no link move side by side. When two packets want the same node or the same output, the nodes' arbiters serialise them, and backpressure from a destination propagates upstream without loss.

Top module: `bfFabric`

## Requirements
- R1: After reset, no destination port shows valid, and every source port shows ready.
- R2: A packet accepted at any source with destination field D (three bits, bit 2 most significant) is delivered on destination port D. At rank r (r = 0, 1, 2), the node forwards to the next-rank column equal to its own column with bit 2-r replaced by destination bit 2-r: a value of 0 takes the link to the column with that bit clear, and a value of 1 takes the link to the column with that bit set.
- R3: Each of ranks 0 to 2 strips one destination bit. A packet leaving rank r carries a remaining header length of 2-r. At the destination port, the header length is 0 and the header bits are all 0.
- R4: The payload (16 bits) and the checksum (8 bits) arrive unchanged.
- R5: A packet accepted at a source on clock edge E appears valid on its destination port after edge E+3 and can be taken on edge E+4. With no contention or backpressure it arrives exactly then, and it never arrives earlier.
- R6: For every constant K, the eight flows "source s to destination s XOR K" share no link. Injected together into an empty fabric with all destinations ready, all eight arrive in the same cycle with the latency of R5. The eight values of K together cover all 64 source/destination pairs.
- R7: While a destination holds ready low, its valid stays high and its header, payload and checksum stay stable. Nothing is dropped.
- R8: When both inputs of a node offer packets on consecutive loads, the node alternates between them. Every accepted packet is delivered exactly once, even when all sources target one destination.
- R9: A last-rank node delivers only on its own destination port. Its second output link never becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| srcValid | input | 8 | Per-source packet offer |
| srcReady | output | 8 | Per-source acceptance; a packet transfers when valid and ready are both high |
| srcDest | input | 8x3 | Per-source destination port number |
| srcData | input | 8x16 | Per-source payload |
| srcChk | input | 8x8 | Per-source checksum, carried unchanged |
| dstValid | output | 8 | Per-destination packet available |
| dstReady | input | 8 | Per-destination acceptance |
| dstHdrLen | output | 8x2 | Remaining header length on delivery (always 0) |
| dstHdr | output | 8x3 | Remaining header bits on delivery (always 0) |
| dstData | output | 8x16 | Delivered payload |
| dstChk | output | 8x8 | Delivered checksum |

## Verification
The properties check the following on every cycle:
- each rank strips one header bit;
- a stalled node or destination holds its packet;
- consecutive contested loads alternate between the two inputs;
- the spare last-rank link stays silent.

Whether a packet lands on the right port with its payload intact, and the exact three-hop timing, can only be shown by the bench's scenarios. These are:
- all eight XOR permutations, which cover every source/destination pair;
- a full stall;
- an all-to-one hotspot;
- random traffic under random backpressure.

A behavioural model tracks every packet in flight and is compared with the outputs on every clock.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;
  parameter int PORTS  = 8;
  parameter int ADDR_W = $clog2(PORTS);
  parameter int RANKS  = ADDR_W + 1;
  parameter int LEN_W  = $clog2(ADDR_W + 1);
  parameter int DATA_W = 16;
  parameter int CHK_W  = 8;

  // Packet as carried on every link: remaining route tag, then the body.
  typedef struct packed {
    logic [LEN_W-1:0]  hdrLen;
    logic [ADDR_W-1:0] hdr;
    logic [DATA_W-1:0] payload;
    logic [CHK_W-1:0]  chk;
  } pkt_t;

  // Strobes from a node's control to its datapath.
  typedef struct packed {
    logic load;
    logic sel;
    logic drain;
  } sw_strobe_t;
endpackage

// File: rtl/bfSwitchCtrl.sv
`timescale 1ns/1ps
module bfSwitchCtrl
  import bfly_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] inValid,
  output logic [1:0] inReady,
  output logic [1:0] outValid,
  input  logic [1:0] outReady,
  input  logic       steer,
  output sw_strobe_t strb
);
  logic full;
  logic rrPtr;
  logic pick;
  logic drain;
  logic canLoad;

  // Round-robin choice between the two inputs (R8).
  always_comb begin
    if (inValid[rrPtr])       pick = rrPtr;
    else if (inValid[~rrPtr]) pick = ~rrPtr;
    else                      pick = rrPtr;
    drain   = full && outReady[steer];
    canLoad = !full || drain;
    inReady = '0;
    inReady[pick] = canLoad;
    outValid = '0;
    outValid[steer] = full;
    strb.load  = canLoad && inValid[pick];
    strb.sel   = pick;
    strb.drain = drain;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      full  <= 1'b0;
      rrPtr <= 1'b0;
    end else begin
      if (strb.load)  full <= 1'b1;
      else if (drain) full <= 1'b0;
      if (strb.load)  rrPtr <= ~pick;
    end
  end

  // R7: a blocked packet stays in place, aimed at the same output.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (full && !outReady[steer]) |=> (full && $stable(steer)));

  // R8: two contested loads in a row come from different inputs.
  p_rr_alt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && (&inValid)) ##1 (strb.load && (&inValid))
      |-> (strb.sel != $past(strb.sel)));
endmodule

// File: rtl/bfSwitchData.sv
`timescale 1ns/1ps
module bfSwitchData
  import bfly_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pkt_t       inPkt [2],
  input  sw_strobe_t strb,
  output pkt_t       pktOut,
  output logic       steer
);
  pkt_t chosen;
  pkt_t nxt;
  logic nxtSteer;

  // R2/R3: take the leading tag bit as the output choice, then strip it.
  always_comb begin
    chosen   = inPkt[strb.sel];
    nxt      = chosen;
    nxtSteer = 1'b0;
    if (chosen.hdrLen != '0) begin
      nxtSteer   = chosen.hdr[ADDR_W-1];
      nxt.hdr    = chosen.hdr << 1;
      nxt.hdrLen = chosen.hdrLen - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktOut <= '0;
      steer  <= 1'b0;
    end else if (strb.load) begin
      pktOut <= nxt;
      steer  <= nxtSteer;
    end else if (strb.drain) begin
      pktOut <= '0;
      steer  <= 1'b0;
    end
  end
endmodule

// File: rtl/bfFabric.sv
`timescale 1ns/1ps
module bfFabric
  import bfly_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [PORTS-1:0]               srcValid,
  output logic [PORTS-1:0]               srcReady,
  input  logic [PORTS-1:0][ADDR_W-1:0]   srcDest,
  input  logic [PORTS-1:0][DATA_W-1:0]   srcData,
  input  logic [PORTS-1:0][CHK_W-1:0]    srcChk,
  output logic [PORTS-1:0]               dstValid,
  input  logic [PORTS-1:0]               dstReady,
  output logic [PORTS-1:0][LEN_W-1:0]    dstHdrLen,
  output logic [PORTS-1:0][ADDR_W-1:0]   dstHdr,
  output logic [PORTS-1:0][DATA_W-1:0]   dstData,
  output logic [PORTS-1:0][CHK_W-1:0]    dstChk
);
  // Per node: two inbound slots, two outbound links, one held packet.
  logic inValidA  [RANKS][PORTS][2];
  logic inReadyA  [RANKS][PORTS][2];
  pkt_t inPktA    [RANKS][PORTS][2];
  logic outValidA [RANKS][PORTS][2];
  logic outReadyA [RANKS][PORTS][2];
  pkt_t nodePkt   [RANKS][PORTS];

  // Switching nodes.
  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    for (genvar c = 0; c < PORTS; c++) begin : g_node
      logic [1:0] inV, inR, oV, oR;
      logic       steer;
      sw_strobe_t strb;

      assign inV = {inValidA[r][c][1], inValidA[r][c][0]};
      assign inReadyA[r][c][0] = inR[0];
      assign inReadyA[r][c][1] = inR[1];
      assign oR = {outReadyA[r][c][1], outReadyA[r][c][0]};
      assign outValidA[r][c][0] = oV[0];
      assign outValidA[r][c][1] = oV[1];

      bfSwitchCtrl u_ctrl (
        .clk(clk), .rstN(rstN),
        .inValid(inV), .inReady(inR),
        .outValid(oV), .outReady(oR),
        .steer(steer), .strb(strb)
      );

      bfSwitchData u_data (
        .clk(clk), .rstN(rstN),
        .inPkt(inPktA[r][c]), .strb(strb),
        .pktOut(nodePkt[r][c]), .steer(steer)
      );

      // R3: header length left on a rank's outputs.
      localparam int LEFT = (r < ADDR_W) ? (ADDR_W - 1 - r) : 0;
      p_strip_r3: assert property (@(posedge clk) disable iff (!rstN)
        (outValidA[r][c][0] || outValidA[r][c][1])
          |-> (nodePkt[r][c].hdrLen == LEN_W'(LEFT)));
    end
  end

  // R2: rank r output k goes to the next-rank column whose bit (ADDR_W-1-r)
  // equals k; slot 0 is the straight link, slot 1 the crossing one.
  for (genvar r = 0; r < RANKS - 1; r++) begin : g_wire
    for (genvar c = 0; c < PORTS; c++) begin : g_col
      for (genvar k = 0; k < 2; k++) begin : g_out
        localparam int MASK = 1 << (ADDR_W - 1 - r);
        localparam int NXT  = (k == 1) ? (c | MASK) : (c & ~MASK);
        localparam int SLOT = (NXT == c) ? 0 : 1;
        assign inValidA[r+1][NXT][SLOT] = outValidA[r][c][k];
        assign inPktA[r+1][NXT][SLOT]   = nodePkt[r][c];
        assign outReadyA[r][c][k]       = inReadyA[r+1][NXT][SLOT];
      end
    end
  end

  // Edge ranks: sources into rank 0, rank RANKS-1 out to destinations.
  for (genvar c = 0; c < PORTS; c++) begin : g_edge
    assign inValidA[0][c][0] = srcValid[c];
    assign inValidA[0][c][1] = 1'b0;
    assign inPktA[0][c][0]   = {LEN_W'(ADDR_W), srcDest[c], srcData[c], srcChk[c]};
    assign inPktA[0][c][1]   = '0;
    assign srcReady[c]       = inReadyA[0][c][0] | inReadyA[0][c][1];

    assign dstValid[c]  = outValidA[RANKS-1][c][0];
    assign dstHdrLen[c] = nodePkt[RANKS-1][c].hdrLen;
    assign dstHdr[c]    = nodePkt[RANKS-1][c].hdr;
    assign dstData[c]   = nodePkt[RANKS-1][c].payload;
    assign dstChk[c]    = nodePkt[RANKS-1][c].chk;
    assign outReadyA[RANKS-1][c][0] = dstReady[c];
    assign outReadyA[RANKS-1][c][1] = 1'b0;

    // R9: the last rank never uses its second link.
    p_spare_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
      !outValidA[RANKS-1][c][1]);

    // R3: delivered header is empty.
    p_empty_hdr_r3: assert property (@(posedge clk) disable iff (!rstN)
      dstValid[c] |-> (dstHdrLen[c] == '0 && dstHdr[c] == '0));

    // R7: a refused delivery stays put.
    p_dst_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (dstValid[c] && !dstReady[c])
        |=> (dstValid[c] && $stable(dstData[c]) && $stable(dstChk[c])));
  end
endmodule

// File: tb/bfFabric_tb.sv
`timescale 1ns/1ps
module bfFabric_tb;
  import bfly_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic                         rstN;
  logic [PORTS-1:0]             srcValid, srcReady, dstValid, dstReady;
  logic [PORTS-1:0][ADDR_W-1:0] srcDest, dstHdr;
  logic [PORTS-1:0][DATA_W-1:0] srcData, dstData;
  logic [PORTS-1:0][CHK_W-1:0]  srcChk, dstChk;
  logic [PORTS-1:0][LEN_W-1:0]  dstHdrLen;

  bfFabric u_dut (
    .clk(clk), .rstN(rstN),
    .srcValid(srcValid), .srcReady(srcReady), .srcDest(srcDest),
    .srcData(srcData), .srcChk(srcChk),
    .dstValid(dstValid), .dstReady(dstReady), .dstHdrLen(dstHdrLen),
    .dstHdr(dstHdr), .dstData(dstData), .dstChk(dstChk)
  );

  int errors = 0;
  int checks = 0;
  int cycle  = 0;
  int seqNo  = 0;
  int readyMode = 0;     // 0 all ready, 1 pseudo-random, 2 none
  bit exactLat = 1'b0;
  int lfsr = 16'hACE1;
  bit done = 1'b0;

  // Reference model: per-source send queues and packets in flight.
  int qDst [PORTS][$];
  int qDat [PORTS][$];
  int pendDst [int];
  int pendCyc [int];
  int pendChk [int];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ckOf(int dat, int d);
    return ((dat * 29) ^ (d * 83)) & 255;
  endfunction

  task automatic enq(int s, int d);
    int dat = (s << 13) | (seqNo & 16'h1FFF);
    seqNo++;
    qDst[s].push_back(d);
    qDat[s].push_back(dat);
  endtask

  function automatic int queued();
    int n = 0;
    for (int s = 0; s < PORTS; s++) n += qDst[s].size();
    return n;
  endfunction

  task automatic step();
    @(posedge clk);
    cycle++;
    #0.5;
    for (int s = 0; s < PORTS; s++) begin
      if (qDst[s].size() > 0) begin
        srcValid[s] = 1'b1;
        srcDest[s]  = ADDR_W'(qDst[s][0]);
        srcData[s]  = DATA_W'(qDat[s][0]);
        srcChk[s]   = CHK_W'(ckOf(qDat[s][0], qDst[s][0]));
      end else begin
        srcValid[s] = 1'b0;
      end
    end
    lfsr = (lfsr & 1) ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
    case (readyMode)
      0: dstReady = '1;
      1: dstReady = PORTS'(lfsr) | PORTS'(lfsr >> 5);
      default: dstReady = '0;
    endcase
    #1;
    // Handshakes that complete on the coming edge.
    for (int s = 0; s < PORTS; s++) begin
      if (srcValid[s] && srcReady[s]) begin
        int key = qDat[s][0];
        pendDst[key] = qDst[s][0];
        pendCyc[key] = cycle;
        pendChk[key] = ckOf(qDat[s][0], qDst[s][0]);
        void'(qDst[s].pop_front());
        void'(qDat[s].pop_front());
      end
    end
    for (int d = 0; d < PORTS; d++) begin
      if (dstValid[d] && dstReady[d]) begin
        int key = int'(dstData[d]);
        if (!pendDst.exists(key)) begin
          check(1'b0, "R8", "unexpected or repeated payload", key, -1);
        end else begin
          int lat = cycle - pendCyc[key];
          check(pendDst[key] == d, "R2", "delivery port", d, pendDst[key]);
          check(dstHdrLen[d] == '0 && dstHdr[d] == '0, "R3", "header empty",
                int'(dstHdrLen[d]) * 8 + int'(dstHdr[d]), 0);
          check(int'(dstChk[d]) == pendChk[key], "R4", "checksum",
                int'(dstChk[d]), pendChk[key]);
          if (exactLat) check(lat == 4, "R6", "conflict-free latency", lat, 4);
          else          check(lat >= 4, "R5", "minimum latency", lat, 4);
          pendDst.delete(key);
          pendCyc.delete(key);
          pendChk.delete(key);
        end
      end
    end
  endtask

  task automatic drain(int limit, string req);
    int n = 0;
    while ((pendDst.num() > 0 || queued() > 0) && n < limit) begin
      step();
      n++;
    end
    check(pendDst.num() == 0 && queued() == 0, req, "all packets delivered",
          pendDst.num() + queued(), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    rstN = 1'b0;
    srcValid = '0; srcDest = '0; srcData = '0; srcChk = '0;
    dstReady = '1;
    repeat (4) @(posedge clk);
    #0.5 rstN = 1'b1;
    #1;
    // R1: reset state.
    check(dstValid == '0, "R1", "dstValid after reset", int'(dstValid), 0);
    check(srcReady == '1, "R1", "srcReady after reset", int'(srcReady), 255);

    // R2/R4/R5/R6: all eight XOR permutations, 64 pairs in total.
    readyMode = 0;
    exactLat  = 1'b1;
    for (int k = 0; k < PORTS; k++) begin
      for (int s = 0; s < PORTS; s++) enq(s, s ^ k);
      drain(40, "R6");
    end

    // R7: full stall, then release.
    begin
      logic [PORTS-1:0][DATA_W-1:0] held;
      exactLat  = 1'b0;
      readyMode = 2;
      for (int s = 0; s < PORTS; s++) enq(s, s ^ 5);
      repeat (8) step();
      check(dstValid == '1, "R7", "valid held while refused", int'(dstValid), 255);
      held = dstData;
      repeat (3) step();
      check(dstValid == '1, "R7", "valid still held", int'(dstValid), 255);
      check(dstData == held, "R7", "payload stable while refused",
            int'(dstData[0]), int'(held[0]));
      readyMode = 0;
      drain(40, "R7");
    end

    // R8: every source sends four packets to destination 3.
    readyMode = 0;
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < PORTS; s++) enq(s, 3);
    drain(200, "R8");

    // R8 with backpressure: hotspot under random readiness.
    readyMode = 1;
    for (int i = 0; i < 3; i++)
      for (int s = 0; s < PORTS; s++) enq(s, 6);
    drain(400, "R8");

    // R2/R4/R5: random destinations, random backpressure.
    for (int i = 0; i < 240; i++) begin
      lfsr = (lfsr & 1) ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
      enq(i % PORTS, (lfsr >> 3) & 7);
    end
    drain(3000, "R2");

    // R9: the spare last-rank link leaves every delivery on its own port;
    // after the traffic no destination still holds a packet.
    readyMode = 0;
    repeat (6) step();
    check(dstValid == '0, "R9", "fabric idle after traffic", int'(dstValid), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 0);
      summary();
      $finish;
    end
  end
endmodule